// File: doc/BRIEF.md
# eMMC Boot Command Detector

This block listens to the command line of an eMMC host interface, sampled on rising edges of the host clock. It picks out three fixed 48-bit command frames that steer a boot-emulation session. The line idles high. A frame opens with a low start bit followed by a high direction bit, and this pair can fall on any bit position. The block therefore waits for the pair, shifts in the whole frame most significant bit first, and compares the result against three constant frames.

Each captured frame ends in exactly one one-cycle verdict pulse. The verdicts are: return to idle, return to pre-idle, start of a boot, or an unrecognised frame. Two side pulses feed the boot data streamer. One starts a transfer. The other aborts any transfer in progress; it fires on both the idle and the pre-idle frame.

The sequencer has three named states. HUNT discards high bits. LEAD holds a seen start bit and waits for the direction bit. FILL shifts the remaining bits in. The transitions are:
- HUNT→LEAD on a low bit.
- LEAD→LEAD on another low bit. The newer low bit becomes the start candidate.
- LEAD→FILL on a high bit. At this point two bits are held.
- FILL→HUNT on the edge that samples the 48th bit. That edge also launches the verdict.

Top module: `emboot_cmd_detector`

## Requirements
- R1: While reset is asserted (active low, asynchronous), and after it is released, all six outputs are low, and the sequencer is hunting with an empty frame register.
- R2: A high bit sampled while hunting is discarded and never produces any output pulse.
- R3: A frame is located by the bit pair 0 then 1 at any bit offset. When several low bits come in a row, the last one before the first high bit is taken as the start bit. Bits are taken most significant first, so the start bit is frame bit 47.
- R4: The frame 0x400000000095 produces `idle_o` and `stream_abort_o` together, as one pulse each.
- R5: The frame 0x40F0F0F0F0FD produces `preidle_o` and `stream_abort_o` together, as one pulse each.
- R6: The frame 0x40FFFFFFFAE5 produces `boot_o` and `stream_start_o` together, as one pulse each.
- R7: Any other 48-bit frame produces `error_o` alone, with neither `stream_start_o` nor `stream_abort_o`.
- R8: The verdict pulses are mutually exclusive. Each lasts one clock. Each is high in the cycle that follows the clock edge sampling the 48th bit, and at no other time.
- R9: Hunting resumes on the same edge that samples the 48th bit. The bit sampled on the very next edge may already be the start bit of a following frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Host clock; the command line is sampled on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_i | input | 1 | eMMC command line, high when idle |
| idle_o | output | 1 | One-cycle pulse: return-to-idle frame recognised |
| preidle_o | output | 1 | One-cycle pulse: return-to-pre-idle frame recognised |
| boot_o | output | 1 | One-cycle pulse: boot-initiation frame recognised |
| error_o | output | 1 | One-cycle pulse: captured frame matched nothing |
| stream_start_o | output | 1 | Starts the boot image streamer |
| stream_abort_o | output | 1 | Aborts a running boot image transfer |

## Verification
The hardest case to reach is a frame boundary that lands where an aligned design would not expect it. This happens when several low bits come before the direction bit, or when a new frame begins on the very first bit after the previous one ends. The stimulus covers both. It varies the run of idle ones before each frame, prefixes frames with extra low bits, and sends frames back to back with no idle bit between them. A behavioural bit-level model in the bench predicts the output on every clock. Near-miss frames, each one bit away from a valid command, are also sent to show that only exact matches count.

// File: rtl/emboot_det_pkg.sv
package emboot_det_pkg;

    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_LEAD = 2'd1,
        ST_FILL = 2'd2
    } hunt_state_t;

    typedef enum logic [2:0] {
        VD_NONE    = 3'd0,
        VD_IDLE    = 3'd1,
        VD_PREIDLE = 3'd2,
        VD_BOOT    = 3'd3,
        VD_ERROR   = 3'd4
    } verdict_t;

    localparam int unsigned CMD_FRAME_BITS = 48;
    localparam logic [CMD_FRAME_BITS-1:0] FRM_IDLE    = 48'h4000_0000_0095;
    localparam logic [CMD_FRAME_BITS-1:0] FRM_PREIDLE = 48'h40F0_F0F0_F0FD;
    localparam logic [CMD_FRAME_BITS-1:0] FRM_BOOT    = 48'h40FF_FFFF_FAE5;

endpackage

// File: rtl/emboot_seq_fsm.sv
module emboot_seq_fsm
    import emboot_det_pkg::*;
#(
    parameter int unsigned FRAME_W = CMD_FRAME_BITS
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        cmd_i,
    output hunt_state_t state_o,
    output logic        seed_o,
    output logic        shift_o,
    output logic        last_o
);
    localparam int unsigned CNT_W     = $clog2(FRAME_W + 1);
    localparam logic [CNT_W-1:0] CNT_SEED = CNT_W'(2);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_W - 1);

    hunt_state_t      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_HUNT;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_HUNT: begin
                if (!cmd_i) state_d = ST_LEAD;
            end
            ST_LEAD: begin
                if (cmd_i) begin
                    state_d = ST_FILL;
                    cnt_d   = CNT_SEED;
                end
            end
            ST_FILL: begin
                if (cnt_q == CNT_LAST) begin
                    state_d = ST_HUNT;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: begin
                state_d = ST_HUNT;
                cnt_d   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        seed_o  = 1'b0;
        shift_o = 1'b0;
        last_o  = 1'b0;
        unique case (state_q)
            ST_HUNT: ;
            ST_LEAD: seed_o = cmd_i;
            ST_FILL: begin
                shift_o = 1'b1;
                last_o  = (cnt_q == CNT_LAST);
            end
            default: ;
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/emboot_frame_shreg.sv
module emboot_frame_shreg #(
    parameter int unsigned FRAME_W = 48
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               cmd_i,
    input  logic               seed_i,
    input  logic               shift_i,
    output logic [FRAME_W-1:0] frame_o
);
    localparam logic [FRAME_W-1:0] SEED_VAL = FRAME_W'(2'b01);

    logic [FRAME_W-1:0] sh_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sh_q <= '0;
        end else if (seed_i) begin
            sh_q <= SEED_VAL;
        end else if (shift_i) begin
            sh_q <= {sh_q[FRAME_W-2:0], cmd_i};
        end
    end

    // frame as it will stand once the current bit is taken
    assign frame_o = {sh_q[FRAME_W-2:0], cmd_i};

endmodule

// File: rtl/emboot_frame_match.sv
module emboot_frame_match
    import emboot_det_pkg::*;
#(
    parameter int unsigned               FRAME_W = CMD_FRAME_BITS,
    parameter int unsigned               N_PAT   = 3,
    parameter logic [N_PAT*FRAME_W-1:0]  PAT_TAB = {FRM_BOOT, FRM_PREIDLE, FRM_IDLE}
) (
    input  logic [FRAME_W-1:0] frame_i,
    output verdict_t           verdict_o
);
    logic [N_PAT-1:0] hit;

    for (genvar gi = 0; gi < N_PAT; gi++) begin : g_cmp
        assign hit[gi] = (frame_i == PAT_TAB[gi*FRAME_W +: FRAME_W]);
    end

    always_comb begin
        verdict_o = VD_ERROR;
        if (hit[0])      verdict_o = VD_IDLE;
        else if (hit[1]) verdict_o = VD_PREIDLE;
        else if (hit[2]) verdict_o = VD_BOOT;
    end

endmodule

// File: rtl/emboot_verdict_out.sv
module emboot_verdict_out
    import emboot_det_pkg::*;
(
    input  logic     clk_i,
    input  logic     rst_ni,
    input  logic     fire_i,
    input  verdict_t verdict_i,
    output logic     idle_o,
    output logic     preidle_o,
    output logic     boot_o,
    output logic     error_o,
    output logic     start_o,
    output logic     abort_o
);
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            idle_o    <= 1'b0;
            preidle_o <= 1'b0;
            boot_o    <= 1'b0;
            error_o   <= 1'b0;
            start_o   <= 1'b0;
            abort_o   <= 1'b0;
        end else begin
            idle_o    <= 1'b0;
            preidle_o <= 1'b0;
            boot_o    <= 1'b0;
            error_o   <= 1'b0;
            start_o   <= 1'b0;
            abort_o   <= 1'b0;
            if (fire_i) begin
                unique case (verdict_i)
                    VD_IDLE: begin
                        idle_o  <= 1'b1;
                        abort_o <= 1'b1;
                    end
                    VD_PREIDLE: begin
                        preidle_o <= 1'b1;
                        abort_o   <= 1'b1;
                    end
                    VD_BOOT: begin
                        boot_o  <= 1'b1;
                        start_o <= 1'b1;
                    end
                    VD_ERROR: error_o <= 1'b1;
                    default:  ;
                endcase
            end
        end
    end

endmodule

// File: rtl/emboot_cmd_detector.sv
module emboot_cmd_detector
    import emboot_det_pkg::*;
#(
    parameter int unsigned                FRAME_W      = CMD_FRAME_BITS,
    parameter logic [FRAME_W-1:0]         PAT_IDLE     = FRM_IDLE,
    parameter logic [FRAME_W-1:0]         PAT_PREIDLE  = FRM_PREIDLE,
    parameter logic [FRAME_W-1:0]         PAT_BOOT     = FRM_BOOT
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic cmd_i,
    output logic idle_o,
    output logic preidle_o,
    output logic boot_o,
    output logic error_o,
    output logic stream_start_o,
    output logic stream_abort_o
);
    localparam int unsigned N_PAT = 3;

    hunt_state_t        state_q;
    logic               seed, shift, last;
    logic [FRAME_W-1:0] frame_nx;
    verdict_t           verdict;

    emboot_seq_fsm #(.FRAME_W(FRAME_W)) u_fsm (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .cmd_i   (cmd_i),
        .state_o (state_q),
        .seed_o  (seed),
        .shift_o (shift),
        .last_o  (last)
    );

    emboot_frame_shreg #(.FRAME_W(FRAME_W)) u_shreg (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .cmd_i   (cmd_i),
        .seed_i  (seed),
        .shift_i (shift),
        .frame_o (frame_nx)
    );

    emboot_frame_match #(
        .FRAME_W (FRAME_W),
        .N_PAT   (N_PAT),
        .PAT_TAB ({PAT_BOOT, PAT_PREIDLE, PAT_IDLE})
    ) u_match (
        .frame_i   (frame_nx),
        .verdict_o (verdict)
    );

    emboot_verdict_out u_out (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .fire_i    (last),
        .verdict_i (verdict),
        .idle_o    (idle_o),
        .preidle_o (preidle_o),
        .boot_o    (boot_o),
        .error_o   (error_o),
        .start_o   (stream_start_o),
        .abort_o   (stream_abort_o)
    );

endmodule

// File: rtl/emboot_cmd_detector_chk.sv
module emboot_cmd_detector_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       cmd_i,
    input logic [1:0] state_i,
    input logic       idle_i,
    input logic       preidle_i,
    input logic       boot_i,
    input logic       error_i,
    input logic       start_i,
    input logic       abort_i
);
    logic any_v;
    assign any_v = idle_i | preidle_i | boot_i | error_i;

    p_onehot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({idle_i, preidle_i, boot_i, error_i}));

    p_single_cycle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        any_v |=> !any_v);

    p_after_fill_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        any_v |-> (state_i == 2'd0 && $past(state_i) == 2'd2));

    p_hunt_ones_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_i == 2'd0 && cmd_i) |=> (state_i == 2'd0 && !any_v));

    p_lead_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_i == 2'd1 && !cmd_i) |=> state_i == 2'd1);

    p_abort_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        abort_i |-> (idle_i || preidle_i));

    p_start_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |-> boot_i);

    p_error_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        error_i |-> (!start_i && !abort_i));

endmodule

bind emboot_cmd_detector emboot_cmd_detector_chk u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cmd_i     (cmd_i),
    .state_i   (state_q),
    .idle_i    (idle_o),
    .preidle_i (preidle_o),
    .boot_i    (boot_o),
    .error_i   (error_o),
    .start_i   (stream_start_o),
    .abort_i   (stream_abort_o)
);

// File: tb/emboot_cmd_detector_test.sv
module emboot_cmd_detector_test;

    localparam logic [47:0] F_IDLE = 48'h4000_0000_0095;
    localparam logic [47:0] F_PRE  = 48'h40F0_F0F0_F0FD;
    localparam logic [47:0] F_BOOT = 48'h40FF_FFFF_FAE5;

    logic clk_i = 1'b0;
    logic rst_ni = 1'b0;
    logic cmd_i = 1'b1;
    logic idle_o, preidle_o, boot_o, error_o, stream_start_o, stream_abort_o;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // behavioural model state
    bit          m_in_frame = 0;
    bit          m_zero = 0;
    logic [47:0] m_frm = '0;
    int          m_n = 0;
    logic [5:0]  exp_v = '0;
    string       exp_tag = "R1";
    string       phase = "";

    always #2.5 clk_i = ~clk_i;

    emboot_cmd_detector uut (
        .clk_i          (clk_i),
        .rst_ni         (rst_ni),
        .cmd_i          (cmd_i),
        .idle_o         (idle_o),
        .preidle_o      (preidle_o),
        .boot_o         (boot_o),
        .error_o        (error_o),
        .stream_start_o (stream_start_o),
        .stream_abort_o (stream_abort_o)
    );

    function automatic logic [5:0] got_v();
        return {idle_o, preidle_o, boot_o, error_o, stream_start_o, stream_abort_o};
    endfunction

    task automatic check_now();
        total++;
        if (got_v() !== exp_v) begin
            bad++;
            $display("FAIL %s: outputs got %b expected %b", exp_tag, got_v(), exp_v);
        end
    endtask

    // order {idle,preidle,boot,error,start,abort}
    task automatic model_bit(input logic b);
        exp_v = '0;
        if (m_in_frame) begin
            m_frm = {m_frm[46:0], b};
            m_n++;
            exp_tag = {"R3 R8 ", phase};
            if (m_n == 48) begin
                m_in_frame = 0;
                m_zero = 0;
                if (m_frm == F_IDLE) begin
                    exp_v = 6'b100001; exp_tag = {"R4 R8 ", phase};
                end else if (m_frm == F_PRE) begin
                    exp_v = 6'b010001; exp_tag = {"R5 R8 ", phase};
                end else if (m_frm == F_BOOT) begin
                    exp_v = 6'b001010; exp_tag = {"R6 R8 ", phase};
                end else begin
                    exp_v = 6'b000100; exp_tag = {"R7 R8 ", phase};
                end
            end
        end else if (m_zero && b) begin
            m_in_frame = 1;
            m_frm = 48'b01;
            m_n = 2;
            m_zero = 0;
            exp_tag = {"R3 ", phase};
        end else begin
            m_zero = !b;
            exp_tag = {"R2 ", phase};
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk_i);
        check_now();
        cmd_i = b;
        model_bit(b);
    endtask

    task automatic send_frame(input logic [47:0] f);
        for (int i = 47; i >= 0; i--) send_bit(f[i]);
    endtask

    task automatic send_ones(input int n);
        for (int i = 0; i < n; i++) send_bit(1'b1);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: outputs quiet under reset
        repeat (3) @(negedge clk_i);
        exp_v = '0; exp_tag = "R1 during reset";
        check_now();
        rst_ni = 1'b1;
        exp_tag = "R1 after release";
        @(negedge clk_i);
        check_now();

        // frame straight after reset, no idle run
        phase = "first";
        send_frame(F_BOOT);

        // R2: long idle run
        phase = "idle run";
        send_ones(40);

        phase = "basic";
        send_frame(F_IDLE);
        send_ones(3);
        send_frame(F_PRE);
        send_ones(5);
        send_frame(F_BOOT);
        send_ones(2);
        send_frame(48'h4012_3456_789A);
        send_ones(4);

        // R3: extra low bits before the direction bit
        phase = "R3 lead zeros";
        send_bit(1'b0); send_bit(1'b0);
        send_frame(F_IDLE);
        send_ones(1);
        send_bit(1'b0);
        send_frame(F_BOOT);
        send_ones(2);

        // R7: near misses
        phase = "R7 near miss";
        send_frame(F_BOOT ^ 48'h1);
        send_ones(1);
        send_frame(F_IDLE ^ 48'h0000_8000_0000);
        send_ones(1);
        send_frame(F_PRE ^ 48'h0100_0000_0000);
        send_ones(3);

        // R9: back-to-back frames
        phase = "R9 back to back";
        send_frame(F_BOOT);
        send_frame(F_IDLE);
        send_frame(F_PRE);
        send_frame(F_BOOT);
        send_ones(2);

        // varied offsets and random frames
        phase = "R3 random offset";
        for (int k = 0; k < 24; k++) begin
            int unsigned sel;
            send_ones(int'($urandom_range(0, 9)));
            sel = $urandom_range(0, 3);
            case (sel)
                0: send_frame(F_IDLE);
                1: send_frame(F_PRE);
                2: send_frame(F_BOOT);
                default: send_frame({2'b01, 14'($urandom), 32'($urandom)});
            endcase
        end
        send_ones(6);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule